// File: doc/BRIEF.md
# Shadow Memory Store/Recall Engine

This block owns two arrays of equal size: a working SRAM that serves ordinary single-cycle reads and writes, and a shadow array that stands in for nonvolatile storage. A store request saves the working contents into the shadow. A store always runs in two passes. The erase pass sets every shadow word to all ones, and the program pass then copies each SRAM word into the shadow. A recall request runs the other way and loads the shadow back into the SRAM.

While either operation runs, `busy` is high and every external access is refused. A store holds `busy` for at least a configurable number of cycles, so software sees a fixed minimum store time whatever the array depth. Both copies move one word per cycle, from word 0 upward.

Top module: `shadow_mem_engine`

## Requirements
- R1: With `busy` low, a rising edge that sees `ce`=1 and `we`=1 writes `wdata` into the SRAM word at `addr`.
- R2: After reset, `busy` and `rdata` are 0. With `busy` low, a rising edge that sees `ce`=1 and `we`=0 loads the SRAM word at `addr` into `rdata`, so it is visible in the following cycle. Any other edge leaves `rdata` unchanged.
- R3: `store_req` seen with `busy` low starts a store, and `busy` is high from the next cycle. The erase pass writes all ones into each shadow word, one per cycle, and is followed by the program pass, which copies SRAM word i into shadow word i. The store holds `busy` for exactly max(2*DEPTH, STORE_CYCLES) cycles.
- R4: `recall_req` seen with `busy` low (and no `store_req`) copies every shadow word into the same SRAM word, holding `busy` for exactly DEPTH cycles.
- R5: While `busy` is high, external writes do not change the SRAM and external reads do not change `rdata`.
- R6: A `store_req` or `recall_req` that arrives while `busy` is high is dropped. `busy` falls at the normal time and stays low afterwards.
- R7: When `store_req` and `recall_req` arrive in the same cycle with `busy` low, only the store runs.
- R8: A write in the same cycle as an accepted store request lands in the SRAM before the copy, so the shadow holds the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Access strobe |
| we | input | 1 | Write select (1 = write, 0 = read) |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| store_req | input | 1 | Start a store (SRAM to shadow) |
| recall_req | input | 1 | Start a recall (shadow to SRAM) |
| busy | output | 1 | Store or recall in progress |

## Verification
Two pairs of functions can meet in one cycle. In the first pair, an external write and a store request are driven on the same edge while `busy` is still low. The write must land and must then appear in the shadow, which is judged by overwriting the SRAM, recalling it and reading that word back. In the second pair, store and recall requests are raised together. The store must win, which is judged by `busy` lasting the full store time rather than DEPTH cycles, and by a later recall returning the saved value.

// File: rtl/shm_pkg.sv
package shm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ERASE   = 3'd1,
        PH_PROGRAM = 3'd2,
        PH_PAD     = 3'd3,
        PH_RECALL  = 3'd4
    } shm_phase_e;

endpackage

// File: rtl/shm_array.sv
module shm_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/shm_seq.sv
module shm_seq
    import shm_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int STORE_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_req,
    input  logic              recall_req,
    output shm_phase_e        phase,
    output logic [ADDR_W-1:0] idx
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int BUSY_STORE = (STORE_CYCLES > 2 * DEPTH) ? STORE_CYCLES : 2 * DEPTH;
    localparam int CNT_W      = $clog2(BUSY_STORE + 1);
    localparam logic [ADDR_W-1:0] LAST_IDX  = ADDR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0]  PAD_LIMIT = CNT_W'(STORE_CYCLES - 1);

    typedef struct packed {
        shm_phase_e        phase;
        logic [ADDR_W-1:0] idx;
        logic [CNT_W-1:0]  cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                st_d.idx = '0;
                st_d.cnt = '0;
                if (store_req) begin
                    st_d.phase = PH_ERASE;
                end else if (recall_req) begin
                    st_d.phase = PH_RECALL;
                end
            end
            PH_ERASE: begin
                st_d.idx = st_q.idx + 1'b1;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.idx == LAST_IDX) begin
                    st_d.phase = PH_PROGRAM;
                end
            end
            PH_PROGRAM: begin
                st_d.idx = st_q.idx + 1'b1;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.idx == LAST_IDX) begin
                    st_d.phase = (st_q.cnt >= PAD_LIMIT) ? PH_IDLE : PH_PAD;
                end
            end
            PH_PAD: begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt >= PAD_LIMIT) begin
                    st_d.phase = PH_IDLE;
                end
            end
            PH_RECALL: begin
                st_d.idx = st_q.idx + 1'b1;
                if (st_q.idx == LAST_IDX) begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, idx: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign idx   = st_q.idx;
endmodule

// File: rtl/shadow_mem_engine.sv
module shadow_mem_engine
    import shm_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 8,
    parameter int STORE_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              store_req,
    input  logic              recall_req,
    output logic              busy
);
    shm_phase_e        phase;
    logic [ADDR_W-1:0] idx;

    logic              ext_wr, ext_rd;
    logic              sram_we;
    logic [ADDR_W-1:0] sram_waddr, sram_raddr;
    logic [DATA_W-1:0] sram_wdata, sram_rdata;
    logic              shd_we;
    logic [DATA_W-1:0] shd_wdata, shd_rdata;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    shm_seq #(
        .ADDR_W      (ADDR_W),
        .STORE_CYCLES(STORE_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_req (store_req),
        .recall_req(recall_req),
        .phase     (phase),
        .idx       (idx)
    );

    always_comb begin
        busy   = (phase != PH_IDLE);
        ext_wr = ce && we && !busy;
        ext_rd = ce && !we && !busy;

        if (phase == PH_RECALL) begin
            sram_we    = 1'b1;
            sram_waddr = idx;
            sram_wdata = shd_rdata;
        end else begin
            sram_we    = ext_wr;
            sram_waddr = addr;
            sram_wdata = wdata;
        end
        sram_raddr = busy ? idx : addr;

        shd_we    = (phase == PH_ERASE) || (phase == PH_PROGRAM);
        shd_wdata = (phase == PH_ERASE) ? {DATA_W{1'b1}} : sram_rdata;

        rdata_d = ext_rd ? sram_rdata : rdata_q;
    end

    shm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sram (
        .clk    (clk),
        .wr_en  (sram_we),
        .wr_addr(sram_waddr),
        .wr_data(sram_wdata),
        .rd_addr(sram_raddr),
        .rd_data(sram_rdata)
    );

    shm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
        .clk    (clk),
        .wr_en  (shd_we),
        .wr_addr(idx),
        .wr_data(shd_wdata),
        .rd_addr(idx),
        .rd_data(shd_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/shm_engine_chk.sv
module shm_engine_chk
    import shm_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 8,
    parameter int STORE_CYCLES = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              store_req,
    input logic              recall_req,
    input logic [DATA_W-1:0] rdata,
    input shm_phase_e        phase,
    input logic              shd_we,
    input logic [DATA_W-1:0] shd_wdata
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int BUSY_STORE = (STORE_CYCLES > 2 * DEPTH) ? STORE_CYCLES : 2 * DEPTH;

    int   run_q;
    logic store_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= 0;
            store_run_q <= 1'b0;
        end else if (!busy && (store_req || recall_req)) begin
            run_q       <= 0;
            store_run_q <= store_req;
        end else if (busy) begin
            run_q <= run_q + 1;
        end
    end

    a_r3_store_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && store_req) |=> (busy && phase == PH_ERASE));

    a_r3_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ERASE) |-> (shd_we && shd_wdata == {DATA_W{1'b1}}));

    a_r3_erase_before_program: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PROGRAM) |-> ($past(phase) == PH_ERASE || $past(phase) == PH_PROGRAM));

    a_r3_store_length: assert property (@(posedge clk) disable iff (!rst_n)
        (store_run_q && $fell(busy)) |-> (run_q == BUSY_STORE));

    a_r4_recall_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!store_run_q && $fell(busy)) |-> (run_q == DEPTH));

    a_r5_rdata_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rdata));

    a_r7_store_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && store_req && recall_req) |=> (phase == PH_ERASE));
endmodule

bind shadow_mem_engine shm_engine_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STORE_CYCLES(STORE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .store_req (store_req),
    .recall_req(recall_req),
    .rdata     (rdata),
    .phase     (phase),
    .shd_we    (shd_we),
    .shd_wdata (shd_wdata)
);

// File: tb/shadow_mem_engine_tb.sv
module shadow_mem_engine_tb;
    localparam int ADDR_W       = 4;
    localparam int DATA_W       = 8;
    localparam int STORE_CYCLES = 100;
    localparam int DEPTH        = 1 << ADDR_W;
    localparam int STORE_LEN    = (STORE_CYCLES > 2 * DEPTH) ? STORE_CYCLES : 2 * DEPTH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce = 1'b0, we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              store_req = 1'b0, recall_req = 1'b0;
    logic              busy;

    int n_checks = 0;
    int n_fail   = 0;
    logic [DATA_W-1:0] model [DEPTH];

    always #2 clk = ~clk;

    shadow_mem_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_CYCLES(STORE_CYCLES)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .store_req(store_req), .recall_req(recall_req), .busy(busy)
    );

    function automatic logic [DATA_W-1:0] pat(int i);
        return DATA_W'(i * 37 + 5);
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        ce = 1'b0; we = 1'b0; store_req = 1'b0; recall_req = 1'b0;
    endtask

    task automatic wr(int a, logic [DATA_W-1:0] d);
        @(negedge clk);
        ce = 1'b1; we = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic rd(int a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        ce = 1'b1; we = 1'b0; addr = ADDR_W'(a);
        @(negedge clk);
        idle_bus();
        d = rdata;
    endtask

    task automatic t_reset();
        check("R2 reset busy", int'(busy), 0);
        check("R2 reset rdata", int'(rdata), 0);
    endtask

    task automatic t_write_read();
        logic [DATA_W-1:0] d;
        for (int i = 0; i < DEPTH; i++) begin
            wr(i, pat(i));
            model[i] = pat(i);
        end
        rd(5, d);
        check("R1/R2 read word 5", int'(d), int'(pat(5)));
        rd(DEPTH - 1, d);
        check("R1/R2 read last word", int'(d), int'(pat(DEPTH - 1)));
        @(negedge clk);
        addr = ADDR_W'(2);
        @(negedge clk);
        check("R2 rdata holds without strobe", int'(rdata), int'(pat(DEPTH - 1)));
    endtask

    task automatic t_store_with_write();
        int n;
        logic [DATA_W-1:0] d;
        rd(1, d);
        @(negedge clk);
        ce = 1'b1; we = 1'b1; addr = ADDR_W'(3); wdata = 8'h5A; store_req = 1'b1;
        model[3] = 8'h5A;
        @(negedge clk);
        idle_bus();
        n = 0;
        while (busy && n < 1000) begin
            n++;
            if (n == 3) begin ce = 1'b1; we = 1'b1; addr = '0; wdata = 8'h00; end
            else if (n == 10) begin ce = 1'b1; we = 1'b0; addr = ADDR_W'(7); end
            else if (n == 20) recall_req = 1'b1;
            else if (n == 40) store_req = 1'b1;
            else idle_bus();
            @(negedge clk);
        end
        idle_bus();
        check("R3 store busy length", n, STORE_LEN);
        check("R5 rdata held through busy", int'(rdata), int'(pat(1)));
        @(negedge clk);
        check("R6 no restart after store", int'(busy), 0);
        @(negedge clk);
        check("R6 still idle", int'(busy), 0);
        rd(0, d);
        check("R5 write during busy ignored", int'(d), int'(pat(0)));
        rd(3, d);
        check("R8 write beside store request", int'(d), 8'h5A);
    endtask

    task automatic t_recall();
        int n;
        int bad;
        logic [DATA_W-1:0] d;
        for (int i = 0; i < DEPTH; i++) wr(i, 8'h11);
        rd(4, d);
        check("R1 overwrite before recall", int'(d), 8'h11);
        @(negedge clk);
        recall_req = 1'b1;
        @(negedge clk);
        idle_bus();
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check("R4 recall busy length", n, DEPTH);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            rd(i, d);
            if (d != model[i]) bad++;
        end
        check("R3/R4 recalled words mismatching", bad, 0);
        rd(3, d);
        check("R8 shadow holds same-cycle write", int'(d), 8'h5A);
    endtask

    task automatic t_both_requests();
        int n;
        logic [DATA_W-1:0] d;
        wr(2, 8'hC3);
        @(negedge clk);
        store_req = 1'b1; recall_req = 1'b1;
        @(negedge clk);
        idle_bus();
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check("R7 joint request runs store", n, STORE_LEN);
        wr(2, 8'h00);
        @(negedge clk);
        recall_req = 1'b1;
        @(negedge clk);
        idle_bus();
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        rd(2, d);
        check("R7 stored value recalled", int'(d), 8'hC3);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_store_with_write();
        t_recall();
        t_both_requests();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule